// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers interrupt requests from ten peripheral sources and an internal interval timer into one sticky status word, gates them by group and by a global enable, and drives a single interrupt line toward the CPU. Software reads the status word to learn which sources fired and writes ones to acknowledge them. The interrupt line can be configured to stay high while anything enabled is pending, or to emit a single-cycle pulse when the pending set goes from empty to non-empty.

Source inputs are sampled every cycle, and a source only needs to be high for one cycle to be recorded. The GPIO banks share one group enable, and so do the three LED blinkers. The SPI, SMBus, one-wire and timer sources each have an enable of their own. The interval timer divides the clock by a power of two chosen by a 4-bit field, with 14 as the largest legal value. It then counts a programmable number of divided ticks and records its own status bit each time the count completes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four registers read as zero and `irq_o` is low.
- R2: Status bits are sticky, and their positions are fixed. Bits 0..3 are GPIO banks A..D (`src_req[3:0]`). Bits 4..6 are LED0..LED2. Bit 7 is SPI, bit 8 is SMBus, bit 9 is one-wire and bit 10 is the timer. A bit is cleared only by writing 1 to it at word address 1. Writing 0 leaves it unchanged.
- R3: When a source is high in the same cycle that software clears its status bit, the bit stays set.
- R4: The control word at word address 0 holds the group enables, and a 1 enables its group. Bit 2 enables GPIO A..D, bit 3 enables LED0..2, and bits 4, 5, 6 and 7 enable SPI, SMBus, one-wire and timer respectively. A pending source whose group is disabled is still recorded in status but does not raise `irq_o`.
- R5: Control bit 0 is the global enable. While it is 0, `irq_o` stays low whatever is pending.
- R6: Control bit 1 selects the line style. With bit 1 at 0 (level), `irq_o` is high in every cycle that follows a cycle with an enabled pending source.
- R7: With control bit 1 at 1 (edge), `irq_o` is a one-cycle pulse. The pulse comes one cycle after the enabled pending set changes from empty to non-empty. No further pulse occurs while that set stays non-empty.
- R8: The prescale word at word address 2 holds a 4-bit divider field in bits 3:0 and a timer enable in bit 4. A written field value above 14 is stored as 14.
- R9: While the timer is enabled, status bit 10 is set every (T+1)·2^P cycles. Here T is the count at word address 3 and P is the divider field. The first setting happens (T+1)·2^P cycles after the prescale write that enables the timer.
- R10: Word addresses 0..3 read back the control word (bits 7:0), status (bits 10:0), prescale word (bits 4:0) and timer count (bits 15:0), with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 control, 1 status, 2 prescale, 3 timer count) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational from registers |
| src_req | input | 10 | Peripheral request levels, bit order as in R2 |
| irq_o | output | 1 | CPU interrupt line |

## Verification
A request or register write that is present at a clock edge changes status, control or prescale at that same edge. The registered `irq_o` follows one edge later, so a source seen at edge E produces its interrupt after edge E+1. Each directed task drives at the falling edge and reads registers right after the edge that captures them. It then waits exactly one more edge before it checks `irq_o`. Timer checks count falling edges from the enabling write until status bit 10 appears and compare that count with (T+1)·2^P.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int N_PERIPH  = 10;
    localparam int N_STAT    = N_PERIPH + 1;
    localparam int TIMER_BIT = N_PERIPH;
    localparam int CTRL_W    = 8;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_PRESC = 2'd2,
        A_TCNT  = 2'd3
    } reg_addr_e;

    // Control bit that enables a given status source.
    function automatic int grp_bit(input int src);
        if (src < 4)      return 2;
        else if (src < 7) return 3;
        else              return src - 3;
    endfunction

endpackage

// File: rtl/irq_agg_gate.sv
module irq_agg_gate
    import irq_agg_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [N_STAT-1:0] status,
    output logic              pend_any
);

    logic [N_STAT-1:0] grp_en;

    for (genvar i = 0; i < N_STAT; i++) begin : g_src
        assign grp_en[i] = ctrl[grp_bit(i)];
    end

    assign pend_any = ctrl[0] & (|(status & grp_en));

endmodule

// File: rtl/irq_agg_timer.sv
module irq_agg_timer #(
    parameter int PS_W   = 4,
    parameter int PS_MAX = 14,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PS_W-1:0]  div_sel,
    input  logic [CNT_W-1:0] period,
    output logic             fire
);

    localparam int PRE_W = (PS_MAX < 1) ? 1 : PS_MAX;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] ticks;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic [PRE_W-1:0] div_mask;
    logic             tick;

    always_comb begin
        div_mask = ~({PRE_W{1'b1}} << div_sel);
        tick     = run && ((tm_q.pre & div_mask) == div_mask);
        fire     = tick && (tm_q.ticks == period);
        tm_d     = tm_q;
        if (restart) begin
            tm_d = '0;
        end else if (run) begin
            tm_d.pre = tm_q.pre + 1'b1;
            if (tick) begin
                tm_d.ticks = fire ? '0 : tm_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PS_W   = 4,
    parameter int PS_MAX = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_PERIPH-1:0] src_req,
    output logic                irq_o
);

    localparam int CNT_W = DATA_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [N_STAT-1:0] status;
        logic              ps_en;
        logic [PS_W-1:0]   ps;
        logic [CNT_W-1:0]  tcnt;
        logic              any_prev;
        logic              irq;
    } state_t;

    state_t st_d, st_q;

    logic [CTRL_W-1:0] ctrl_q;
    logic [N_STAT-1:0] status_q;
    logic [PS_W-1:0]   ps_q;
    logic              pend_any;
    logic              tmr_fire;
    logic              wr_en;
    logic              presc_wr;
    reg_addr_e         addr;

    assign ctrl_q   = st_q.ctrl;
    assign status_q = st_q.status;
    assign ps_q     = st_q.ps;
    assign irq_o    = st_q.irq;
    assign addr     = reg_addr_e'(bus_addr);
    assign wr_en    = bus_sel & bus_wr;
    assign presc_wr = wr_en && (addr == A_PRESC);

    irq_agg_gate u_gate (
        .ctrl     (ctrl_q),
        .status   (status_q),
        .pend_any (pend_any)
    );

    irq_agg_timer #(
        .PS_W   (PS_W),
        .PS_MAX (PS_MAX),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (presc_wr),
        .run     (st_q.ps_en),
        .div_sel (st_q.ps),
        .period  (st_q.tcnt),
        .fire    (tmr_fire)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                A_CTRL:  st_d.ctrl   = bus_wdata[CTRL_W-1:0];
                A_STAT:  st_d.status = st_q.status & ~bus_wdata[N_STAT-1:0];
                A_PRESC: begin
                    st_d.ps_en = bus_wdata[PS_W];
                    st_d.ps    = (bus_wdata[PS_W-1:0] > PS_W'(PS_MAX))
                               ? PS_W'(PS_MAX) : bus_wdata[PS_W-1:0];
                end
                A_TCNT:  st_d.tcnt   = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        st_d.status   = st_d.status | {tmr_fire, src_req};
        st_d.any_prev = pend_any;
        st_d.irq      = st_q.ctrl[1] ? (pend_any & ~st_q.any_prev) : pend_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            A_CTRL:  bus_rdata[CTRL_W-1:0] = st_q.ctrl;
            A_STAT:  bus_rdata[N_STAT-1:0] = st_q.status;
            A_PRESC: bus_rdata[PS_W:0]     = {st_q.ps_en, st_q.ps};
            A_TCNT:  bus_rdata[CNT_W-1:0]  = st_q.tcnt;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int PS_W   = 4,
    parameter int PS_MAX = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [1:0]      bus_addr,
    input logic [7:0]      ctrl_q,
    input logic [10:0]     status_q,
    input logic [PS_W-1:0] ps_q,
    input logic            irq_o
);

    // R5
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |=> !irq_o);

    // R7
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ctrl_q[1]) |=> !irq_o);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_wr && bus_addr == 2'd1)
        |-> ((status_q & $past(status_q)) == $past(status_q)));

    // R8
    ps_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_q <= PS_W'(PS_MAX));

    // R4
    all_groups_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7:2] == 6'd0) |=> !irq_o);

    // R6
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !ctrl_q[1] && ctrl_q[2] && (status_q[3:0] != 4'd0)) |=> irq_o);

endmodule

bind irq_aggregator irq_agg_chk #(
    .PS_W   (PS_W),
    .PS_MAX (PS_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .ps_q     (ps_q),
    .irq_o    (irq_o)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [9:0]  src_req = 10'd0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_req   (src_req),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [9:0] m);
        src_req = m;
        cyc(1);
        src_req = '0;
    endtask

    task automatic cleanup();
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h07FF);
        cyc(2);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset irq", irq_o, 0);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        pulse(10'h201);
        cyc(2);
        rd(2'd1, v); check("R2 sticky GPIO A and one-wire", v, 16'h0201);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check("R2 write zero keeps", v, 16'h0201);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); check("R2 clear bit0", v, 16'h0200);
        wr(2'd1, 16'h0200);
        rd(2'd1, v); check("R2 clear bit9", v, 16'h0000);
        pulse(10'h090);
        rd(2'd1, v); check("R2 LED0 and SPI positions", v, 16'h0090);
        cleanup();
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        src_req = 10'h080;
        wr(2'd1, 16'h0080);
        src_req = '0;
        rd(2'd1, v); check("R3 set beats clear", v, 16'h0080);
        cleanup();
    endtask

    task automatic t_level();
        wr(2'd0, 16'h0005);
        check("R6 idle low", irq_o, 0);
        pulse(10'h004);
        check("R6 not yet", irq_o, 0);
        cyc(1);
        check("R6 level high", irq_o, 1);
        cyc(3);
        check("R6 level held", irq_o, 1);
        wr(2'd1, 16'h0004);
        cyc(1);
        check("R6 low after ack", irq_o, 0);
        cleanup();
    endtask

    task automatic t_global();
        logic [15:0] v;
        wr(2'd0, 16'h0004);
        pulse(10'h001);
        cyc(2);
        check("R5 global off", irq_o, 0);
        rd(2'd1, v); check("R5 still recorded", v, 16'h0001);
        wr(2'd0, 16'h0005);
        cyc(1);
        check("R5 global on", irq_o, 1);
        cleanup();
    endtask

    task automatic t_masks();
        for (int i = 0; i < 10; i++) begin
            int g;
            logic [15:0] v;
            g = (i < 4) ? 2 : (i < 7) ? 3 : i - 3;
            wr(2'd0, 16'h00FD & ~(16'h1 << g));
            pulse(10'h1 << i);
            cyc(1);
            check($sformatf("R4 src %0d group off", i), irq_o, 0);
            rd(2'd1, v); check($sformatf("R4 src %0d recorded", i), v, 16'h1 << i);
            wr(2'd0, 16'h0001 | (16'h1 << g));
            cyc(1);
            check($sformatf("R4 src %0d group on", i), irq_o, 1);
            cleanup();
        end
    endtask

    task automatic t_edge();
        int hits;
        wr(2'd0, 16'h0007);
        hits = 0;
        src_req = 10'h002;
        for (int k = 0; k < 6; k++) begin cyc(1); hits += int'(irq_o); end
        src_req = '0;
        check("R7 single pulse", hits, 1);
        hits = 0;
        src_req = 10'h008;
        for (int k = 0; k < 4; k++) begin cyc(1); hits += int'(irq_o); end
        src_req = '0;
        check("R7 no pulse while pending", hits, 0);
        wr(2'd1, 16'h07FF);
        cyc(2);
        hits = 0;
        pulse(10'h001);
        for (int k = 0; k < 4; k++) begin hits += int'(irq_o); cyc(1); end
        check("R7 new pulse after empty", hits, 1);
        cleanup();
    endtask

    task automatic t_clamp();
        logic [15:0] v;
        wr(2'd2, 16'h000F);
        rd(2'd2, v); check("R8 clamp 15", v, 16'h000E);
        wr(2'd2, 16'h000D);
        rd(2'd2, v); check("R8 keep 13", v, 16'h000D);
        wr(2'd2, 16'h001F);
        rd(2'd2, v); check("R8 clamp with enable", v, 16'h001E);
        wr(2'd2, 16'h0000);
        cleanup();
    endtask

    task automatic timer_run(input int t, input int p, input string tag);
        logic [15:0] v;
        int n;
        wr(2'd3, 16'(t));
        wr(2'd2, 16'h0010 | 16'(p));
        n = 0;
        v = 0;
        while (v[10] == 1'b0 && n < 200) begin
            cyc(1);
            n++;
            rd(2'd1, v);
        end
        check({"R9 period ", tag}, n, (t + 1) * (1 << p));
        cyc(1);
        check({"R9 irq ", tag}, irq_o, 1);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h07FF);
        cyc(2);
    endtask

    task automatic t_timer();
        wr(2'd0, 16'h0081);
        timer_run(2, 1, "t2 p1");
        timer_run(0, 0, "t0 p0");
        timer_run(3, 2, "t3 p2");
        cleanup();
    endtask

    task automatic t_readback();
        logic [15:0] v;
        wr(2'd0, 16'h00A4);
        rd(2'd0, v); check("R10 control", v, 16'h00A4);
        wr(2'd3, 16'hBEEF);
        rd(2'd3, v); check("R10 timer count", v, 16'hBEEF);
        wr(2'd2, 16'h0007);
        rd(2'd2, v); check("R10 prescale", v, 16'h0007);
        wr(2'd3, 16'h0000);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_sticky();
        t_set_wins();
        t_level();
        t_global();
        t_masks();
        t_edge();
        t_clamp();
        t_timer();
        t_readback();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule